// File: doc/BRIEF.md
# Disk Command Retry Sequencer

This block supervises one disk command from start to final status. A start request carries a command tag. The block then issues the command to the controller and waits for a completion pulse that carries an 8-bit result code. A cycle-count watchdog runs beside that wait. The upper nibble of the result code selects one of four courses:
- finish successfully;
- issue the command again;
- ask the controller to reset, wait for its acknowledge, then issue the command again;
- stop and report.

A watchdog expiry takes the reset course. The reset wait has its own, shorter timeout.

The number of attempts is bounded. When the bound is reached on a retryable outcome, the block reports the general-failure code 0xFF. It also reports 0xFF when a controller reset is never acknowledged. The final status is a single-cycle strobe that carries the tag, the code and the number of attempts used.

Top module: `cmd_retry_seq`

## Requirements
- R1: After reset, `busy_o`, `launch_o`, `ctl_rst_req_o` and `fin_valid_o` are all low.
- R2: A start request sampled while idle raises `launch_o` for exactly one cycle, in the cycle after the start, with `launch_tag_o` equal to the start tag. A start request while a command is in flight is ignored: it causes no extra launch and does not change the reported tag.
- R3: A result code of 0x00, or any code with upper nibble 0x3 (recovered), ends the command. The final code equals the received code.
- R4: Codes with upper nibble 0x1, 0x2 or 0x9 are program or write-protect errors. The fatal codes 0xE1 to 0xF6, and any other code outside classes 0x0/0x3/0x4/0x6, end the command at once with that code and no retry.
- R5: A code with upper nibble 0x4 relaunches the command directly, with no reset request.
- R6: A code with upper nibble 0x6 raises `ctl_rst_req_o` and holds it until `ctl_rst_ack_i`. The cycle after the acknowledge relaunches the command.
- R7: If no completion arrives within CMD_CYCLES cycles after the launch cycle, the reset course of R6 is taken. `ctl_rst_req_o` first rises CMD_CYCLES+1 cycles after the launch cycle. A completion in the last cycle of the window is accepted instead.
- R8: At most MAX_TRIES launches occur per command. A retryable outcome on the last attempt reports 0xFF with the attempt count equal to MAX_TRIES.
- R9: If the acknowledge does not arrive within RST_CYCLES cycles of the reset request rising, the block reports 0xFF with no further launch. An acknowledge in the last of those cycles is accepted.
- R10: `fin_valid_o` is high for exactly one cycle per command. In that cycle `fin_tag_o`, `fin_code_o` and `fin_tries_o` (the number of launches) are valid. The block is idle on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request |
| start_tag_i | input | TAG_W | Tag of the requested command |
| launch_o | output | 1 | One-cycle command issue strobe |
| launch_tag_o | output | TAG_W | Tag of the command being issued |
| done_i | input | 1 | Completion pulse from the controller |
| code_i | input | 8 | Result code, valid with `done_i` |
| ctl_rst_req_o | output | 1 | Controller reset request, level |
| ctl_rst_ack_i | input | 1 | Controller reset acknowledge |
| busy_o | output | 1 | A command is in flight |
| fin_valid_o | output | 1 | Final status strobe |
| fin_tag_o | output | TAG_W | Tag of the finished command |
| fin_code_o | output | 8 | Last result code, or 0xFF on exhaustion or failed reset |
| fin_tries_o | output | TRY_W | Number of launches used |

## Verification
Two events can fall in the same cycle. The first is a completion that arrives exactly as the command watchdog expires. The second is a reset acknowledge that arrives exactly as the reset timeout expires. The bench provokes the first by placing the completion CMD_CYCLES cycles after the observed launch, and the second by placing the acknowledge RST_CYCLES-1 cycles after the reset request is first seen. In both cases the arriving event must win: the command completes with no reset request, or the relaunch follows instead of a 0xFF report. Random runs spread completion delays across the whole window, including its last cycle, and compare tag, code, attempt count and reset count with a bench model.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_WAIT,
    ST_RESET,
    ST_REPORT
  } seq_state_t;

  typedef enum logic [1:0] {
    ACT_OK,
    ACT_RETRY,
    ACT_RESET,
    ACT_STOP
  } seq_act_t;

  localparam logic [7:0] CODE_GIVEUP = 8'hFF;

  function automatic seq_act_t classify(input logic [7:0] code);
    seq_act_t a;
    unique case (code[7:4])
      4'h0:    a = (code[3:0] == 4'h0) ? ACT_OK : ACT_STOP;
      4'h3:    a = ACT_OK;
      4'h4:    a = ACT_RETRY;
      4'h6:    a = ACT_RESET;
      default: a = ACT_STOP; // program, write-protect, fatal, undefined
    endcase
    return a;
  endfunction

endpackage

// File: rtl/seq_classify.sv
module seq_classify
  import cmd_seq_pkg::*;
(
  input  logic [7:0] code_i,
  output seq_act_t   act_o
);
  assign act_o = classify(code_i);
endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/cmd_retry_seq.sv
module cmd_retry_seq
  import cmd_seq_pkg::*;
#(
  parameter int unsigned TAG_W      = 8,
  parameter int unsigned MAX_TRIES  = 4,
  parameter int unsigned CMD_CYCLES = 400_000_000, // 4 s at 100 MHz
  parameter int unsigned RST_CYCLES = 100_000_000, // 1 s at 100 MHz
  localparam int unsigned TRY_W     = $clog2(MAX_TRIES + 1),
  localparam int unsigned MAX_CYC   = (CMD_CYCLES > RST_CYCLES) ? CMD_CYCLES : RST_CYCLES,
  localparam int unsigned CNT_W     = $clog2(MAX_CYC) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TAG_W-1:0] start_tag_i,
  output logic             launch_o,
  output logic [TAG_W-1:0] launch_tag_o,
  input  logic             done_i,
  input  logic [7:0]       code_i,
  output logic             ctl_rst_req_o,
  input  logic             ctl_rst_ack_i,
  output logic             busy_o,
  output logic             fin_valid_o,
  output logic [TAG_W-1:0] fin_tag_o,
  output logic [7:0]       fin_code_o,
  output logic [TRY_W-1:0] fin_tries_o
);

  localparam logic [CNT_W-1:0] CMD_LOAD = CNT_W'(CMD_CYCLES - 1);
  localparam logic [CNT_W-1:0] RST_LOAD = CNT_W'(RST_CYCLES - 1);
  localparam logic [TRY_W-1:0] TRY_MAX  = TRY_W'(MAX_TRIES);

  seq_state_t       state_q, state_d;
  logic [TAG_W-1:0] tag_q;
  logic [TRY_W-1:0] tries_q;
  logic [7:0]       code_q, code_d;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  seq_act_t         act;
  logic             tries_left;

  seq_classify u_cls (
    .code_i (code_i),
    .act_o  (act)
  );

  seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  assign tries_left = (tries_q < TRY_MAX);

  always_comb begin
    state_d  = state_q;
    code_d   = code_q;
    tmr_load = 1'b0;
    tmr_val  = CMD_LOAD;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_LAUNCH;
      ST_LAUNCH: begin
        tmr_load = 1'b1;
        state_d  = ST_WAIT;
      end
      ST_WAIT: begin
        if (done_i) begin
          code_d = code_i;
          unique case (act)
            ACT_OK, ACT_STOP: state_d = ST_REPORT;
            ACT_RETRY: begin
              if (tries_left) state_d = ST_LAUNCH;
              else begin state_d = ST_REPORT; code_d = CODE_GIVEUP; end
            end
            ACT_RESET: begin
              if (tries_left) begin
                state_d = ST_RESET; tmr_load = 1'b1; tmr_val = RST_LOAD;
              end else begin
                state_d = ST_REPORT; code_d = CODE_GIVEUP;
              end
            end
            default: state_d = ST_REPORT;
          endcase
        end else if (tmr_zero) begin
          // watchdog expiry takes the reset course
          if (tries_left) begin
            state_d = ST_RESET; tmr_load = 1'b1; tmr_val = RST_LOAD;
          end else begin
            state_d = ST_REPORT; code_d = CODE_GIVEUP;
          end
        end
      end
      ST_RESET: begin
        if (ctl_rst_ack_i) state_d = ST_LAUNCH;
        else if (tmr_zero) begin
          state_d = ST_REPORT; code_d = CODE_GIVEUP;
        end
      end
      ST_REPORT: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tag_q   <= '0;
      tries_q <= '0;
      code_q  <= '0;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
      if (state_q == ST_IDLE && start_i) begin
        tag_q   <= start_tag_i;
        tries_q <= '0;
        code_q  <= '0;
      end
      if (state_q == ST_LAUNCH) tries_q <= tries_q + 1'b1;
    end
  end

  assign launch_o      = (state_q == ST_LAUNCH);
  assign launch_tag_o  = tag_q;
  assign ctl_rst_req_o = (state_q == ST_RESET);
  assign busy_o        = (state_q != ST_IDLE);
  assign fin_valid_o   = (state_q == ST_REPORT);
  assign fin_tag_o     = tag_q;
  assign fin_code_o    = code_q;
  assign fin_tries_o   = tries_q;

endmodule

// File: rtl/cmd_retry_seq_chk.sv
module cmd_retry_seq_chk #(
  parameter int unsigned MAX_TRIES = 4,
  parameter int unsigned TRY_W     = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctl_rst_ack_i,
  input logic             launch_o,
  input logic             ctl_rst_req_o,
  input logic             busy_o,
  input logic             fin_valid_o,
  input logic [TRY_W-1:0] fin_tries_o
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!launch_o && !ctl_rst_req_o && !fin_valid_o));

  // R2
  launch_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> !launch_o);

  // R6
  rst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_rst_req_o && !ctl_rst_ack_i) |=> (ctl_rst_req_o || fin_valid_o));

  // R6
  rst_relaunch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_rst_req_o && ctl_rst_ack_i) |=> launch_o);

  // R8
  tries_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_valid_o |-> (fin_tries_o >= 1 && fin_tries_o <= TRY_W'(MAX_TRIES)));

  // R10
  fin_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_valid_o |=> (!fin_valid_o && !busy_o));

endmodule

bind cmd_retry_seq cmd_retry_seq_chk #(.MAX_TRIES(MAX_TRIES), .TRY_W(TRY_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ctl_rst_ack_i (ctl_rst_ack_i),
  .launch_o      (launch_o),
  .ctl_rst_req_o (ctl_rst_req_o),
  .busy_o        (busy_o),
  .fin_valid_o   (fin_valid_o),
  .fin_tries_o   (fin_tries_o)
);

// File: tb/cmd_retry_seq_bench.sv
`timescale 1ns/1ps
module cmd_retry_seq_bench;
  localparam int TAG_W = 8;
  localparam int MAXT  = 4;
  localparam int CMD   = 24;
  localparam int RST   = 12;
  localparam int TRY_W = $clog2(MAXT + 1);

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [TAG_W-1:0] start_tag_i = '0;
  logic             launch_o;
  logic [TAG_W-1:0] launch_tag_o;
  logic             done_i = 1'b0;
  logic [7:0]       code_i = '0;
  logic             ctl_rst_req_o;
  logic             ctl_rst_ack_i = 1'b0;
  logic             busy_o, fin_valid_o;
  logic [TAG_W-1:0] fin_tag_o;
  logic [7:0]       fin_code_o;
  logic [TRY_W-1:0] fin_tries_o;

  always #5 clk = ~clk;

  cmd_retry_seq #(.TAG_W(TAG_W), .MAX_TRIES(MAXT), .CMD_CYCLES(CMD), .RST_CYCLES(RST)) u_cmd_retry_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .start_tag_i(start_tag_i),
    .launch_o(launch_o), .launch_tag_o(launch_tag_o), .done_i(done_i), .code_i(code_i),
    .ctl_rst_req_o(ctl_rst_req_o), .ctl_rst_ack_i(ctl_rst_ack_i), .busy_o(busy_o),
    .fin_valid_o(fin_valid_o), .fin_tag_o(fin_tag_o), .fin_code_o(fin_code_o),
    .fin_tries_o(fin_tries_o)
  );

  int n_chk = 0, n_fail = 0;
  // per-attempt script: kind 0 = completes after dly cycles, 1 = silent
  int         kind [MAXT];
  logic [7:0] codes[MAXT];
  int         dly  [MAXT];
  bit         rst_ok;
  int         rst_dly;
  bit         inject;
  int         wdelta;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // 0 ends ok, 1 retry, 2 reset then retry, 3 stop
  function automatic int bcls(input logic [7:0] c);
    if (c == 8'h00 || c[7:4] == 4'h3) return 0;
    if (c[7:4] == 4'h4) return 1;
    if (c[7:4] == 4'h6) return 2;
    return 3;
  endfunction

  function automatic void model(output logic [7:0] c, output int t, output int r);
    r = 0; t = 0; c = 8'h00;
    for (int a = 0; a < MAXT; a++) begin
      int k;
      t = a + 1;
      k = (kind[a] == 1) ? 2 : bcls(codes[a]);
      if (k == 0 || k == 3) begin c = codes[a]; return; end
      if (t >= MAXT) begin c = 8'hFF; return; end
      if (k == 2) begin
        r++;
        if (!rst_ok) begin c = 8'hFF; return; end
      end
    end
  endfunction

  task automatic set_all(input int k, input logic [7:0] c, input int d);
    for (int i = 0; i < MAXT; i++) begin kind[i] = k; codes[i] = c; dly[i] = d; end
    rst_ok = 1'b1; rst_dly = 2; inject = 1'b0;
  endtask

  task automatic run_case(input string req, input logic [7:0] tag);
    logic [7:0] ec; int et, er;
    int launches = 0, resets = 0, att = 0, dctr = -1, actr = -1, cyc = 0, lcyc = 0;
    bit got = 0, req_prev = 0, inj_pend = 0;
    logic [7:0] gcode; int gtries; logic [7:0] gtag;
    model(ec, et, er);
    wdelta = -1;
    @(negedge clk); start_i = 1'b1; start_tag_i = tag;
    @(negedge clk);
    while (!got && cyc < 3000) begin
      start_i = 1'b0; done_i = 1'b0; ctl_rst_ack_i = 1'b0;
      if (inj_pend) begin start_i = 1'b1; start_tag_i = tag ^ 8'h55; inj_pend = 0; end
      if (dctr > 0) begin
        dctr--;
        if (dctr == 0) begin done_i = 1'b1; code_i = codes[att-1]; dctr = -1; end
      end
      if (launch_o) begin
        launches++; att++; lcyc = cyc;
        chk(launch_tag_o == tag, "R2", "launch tag", launch_tag_o, tag);
        if (att <= MAXT && kind[att-1] == 0) dctr = dly[att-1];
        if (inject && att == 1) inj_pend = 1;
      end
      if (ctl_rst_req_o && !req_prev) begin
        resets++; wdelta = cyc - lcyc;
        if (rst_ok) actr = rst_dly;
      end
      req_prev = ctl_rst_req_o;
      if (actr == 0) begin ctl_rst_ack_i = 1'b1; actr = -1; end
      else if (actr > 0) actr--;
      if (fin_valid_o) begin
        got = 1; gcode = fin_code_o; gtries = int'(fin_tries_o); gtag = fin_tag_o;
      end else begin
        @(negedge clk); cyc++;
      end
    end
    start_i = 1'b0; done_i = 1'b0; ctl_rst_ack_i = 1'b0;
    chk(got, "R10", "final strobe seen", got, 1);
    chk(gcode == ec, req, "final code", gcode, ec);
    chk(gtries == et, "R8", "attempt count", gtries, et);
    chk(launches == et, "R8", "launch count", launches, et);
    chk(resets == er, req, "reset count", resets, er);
    chk(gtag == tag, "R10", "final tag", gtag, tag);
    @(negedge clk);
    chk(!fin_valid_o && !busy_o, "R10", "one-cycle strobe then idle", {fin_valid_o, busy_o}, 0);
  endtask

  function automatic logic [7:0] rand_code();
    case ($urandom % 6)
      0: return 8'h00;
      1: return 8'h30 | 8'($urandom % 16);
      2: return 8'h40 | 8'($urandom % 16);
      3: return 8'h60 | 8'($urandom % 5);
      4: return ($urandom % 3 == 0) ? 8'h90 : (8'h10 | 8'($urandom % 32));
      default: return 8'hE1 + 8'($urandom % 22);
    endcase
  endfunction

  initial begin : wdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy_o && !launch_o && !ctl_rst_req_o && !fin_valid_o, "R1", "reset outputs",
        {busy_o, launch_o, ctl_rst_req_o, fin_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy_o && !fin_valid_o, "R1", "idle after reset", {busy_o, fin_valid_o}, 0);

    set_all(0, 8'h00, 3);  run_case("R3", 8'h11);
    set_all(0, 8'h31, 5);  run_case("R3", 8'h12);
    set_all(0, 8'h12, 2);  run_case("R4", 8'h13);
    set_all(0, 8'h90, 2);  run_case("R4", 8'h14);
    set_all(0, 8'hE4, 2);  run_case("R4", 8'h15);
    set_all(0, 8'h00, 2); codes[0] = 8'h41; run_case("R5", 8'h16);
    set_all(0, 8'h00, 2); codes[0] = 8'h64; rst_dly = 3; run_case("R6", 8'h17);
    set_all(0, 8'h40, 1);  run_case("R8", 8'h18);
    set_all(0, 8'h00, 4); kind[0] = 1; run_case("R7", 8'h19);
    chk(wdelta == CMD + 1, "R7", "watchdog reset timing", wdelta, CMD + 1);
    set_all(0, 8'h00, CMD); run_case("R7", 8'h1A); // completion on expiry cycle wins
    set_all(0, 8'h60, 2); rst_ok = 1'b0; run_case("R9", 8'h1B);
    set_all(0, 8'h00, 2); codes[0] = 8'h60; rst_dly = RST - 1; run_case("R9", 8'h1C);
    set_all(0, 8'h00, 6); inject = 1'b1; run_case("R2", 8'h1D);
    set_all(1, 8'h00, 1);  run_case("R8", 8'h1E);

    for (int n = 0; n < 80; n++) begin
      for (int i = 0; i < MAXT; i++) begin
        kind[i]  = ($urandom % 6 == 0) ? 1 : 0;
        codes[i] = rand_code();
        dly[i]   = 1 + int'($urandom % CMD);
      end
      rst_ok  = ($urandom % 10) != 0;
      rst_dly = int'($urandom % RST);
      inject  = ($urandom % 4) == 0;
      run_case("R5", 8'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule